// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Square-Wave Output

This block is a 16-bit counter with a 16-bit reload register. It has two uses. In the first it is an auto-reload timer whose count direction can come from an external pin. Each wrap raises an interrupt flag and inverts a second flag, so the second flag works as a seventeenth count bit. In the second it is a programmable square-wave generator with a 50% duty cycle, and its wraps raise no interrupt.

Count steps come from one of two sources. The first is an internal prescaler that issues one step every `DIV` system clock cycles. The second is an external count pin, which passes through a two-flop synchroniser and gives one step on each falling edge. A run input gates both sources.

Software reaches the block through a byte-wide write port. It can load the two counter bytes and the two reload bytes, and it can write both flags.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the count, the reload value, both flags and `clk_out` are all 0. A down-counting step taken straight after reset therefore matches the reload value and wraps on the first step.
- R2: When `ext_sel`=0 the counter takes one step every `DIV` clock cycles while `run`=1. When `ext_sel`=1 it takes one step for each synchronised falling edge of `ext_clk_pin`. While `run`=0 it takes no steps.
- R3: Down counting applies when `dir_en`=1 and the synchronised `dir_pin` is 0. Each step subtracts one. A step taken while the count equals the reload value loads 0xFFFF instead.
- R4: Up counting applies when `dir_pin`=1 or `dir_en`=0. Each step adds one. A step taken from 0xFFFF loads the reload value instead.
- R5: Every wrap in R3 or R4 sets `tmr_flag` and inverts `ext_flag`. Both flags keep their values until they are written at address 4. Bit 0 of the write data goes to `tmr_flag` and bit 1 goes to `ext_flag`.
- R6: A flag write in the same cycle as a wrap loses. `tmr_flag` ends at 1, and `ext_flag` ends at the inverse of its previous value.
- R7: The write addresses are 0 for the count low byte, 1 for the count high byte, 2 for the reload low byte and 3 for the reload high byte. A write to either count byte cancels any step in that cycle, including its wrap and flag update. The count byte that is not written keeps its value.
- R8: Square-wave mode applies when `clkout_en`=1, `ext_sel`=0 and `run`=1. In this mode the counter counts up whatever the direction inputs say, and `clk_out` inverts on every wrap. Each half period is therefore (65536 − reload) × `DIV` clock cycles. Outside this mode `clk_out` is 0.
- R9: In square-wave mode, wraps leave `tmr_flag` and `ext_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables counting |
| ext_sel | input | 1 | 0: prescaled clock, 1: external count pin |
| dir_en | input | 1 | Lets `dir_pin` choose the count direction |
| dir_pin | input | 1 | Direction pin, 1 up, 0 down (asynchronous) |
| ext_clk_pin | input | 1 | External count pin (asynchronous) |
| clkout_en | input | 1 | Requests square-wave mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..4) |
| wr_data | input | 8 | Register write data |
| tmr_flag | output | 1 | Interrupt flag |
| ext_flag | output | 1 | Toggle flag (seventeenth bit) |
| clk_out | output | 1 | Square-wave output |

## Verification
The first step after `run` rises lands on the `DIV`-th clock edge, and later steps follow every `DIV` edges. A wrap that needs N steps therefore shows on the flags N × `DIV` cycles after `run` is raised. The next wrap follows (65536 − reload) × `DIV` cycles after that one. In the external mode a falling pin edge becomes a step on the third clock edge, so the bench holds each pin level for four cycles before it looks at a flag. The bench samples on falling clock edges and counts elapsed cycles until each flag or `clk_out` changes. It then compares that count with the figure computed from the start value, the reload value and `DIV`. The priority and override cases drive their write so that it is sampled on exactly the edge of the predicted wrap.

// File: rtl/urt_pkg.sv
package urt_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_RLD_LO = 3'd2,
        A_RLD_HI = 3'd3,
        A_FLAGS  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             tf;
        logic             xf;
        logic             co;
    } core_st_t;
endpackage

// File: rtl/urt_tick_src.sv
module urt_tick_src #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_sel,
    input  logic dir_pin,
    input  logic ext_pin,
    output logic tick,
    output logic dir_up
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [1:0]    xs;
        logic          xprev;
        logic [1:0]    ds;
    } src_st_t;

    src_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // prescaler only runs for the internal source
        if (run && !ext_sel) begin
            st_d.pre = (st_q.pre == LAST) ? '0 : st_q.pre + 1'b1;
        end else begin
            st_d.pre = '0;
        end
        st_d.xs    = {st_q.xs[0], ext_pin};
        st_d.xprev = st_q.xs[1];
        st_d.ds    = {st_q.ds[0], dir_pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick   = run && (ext_sel ? (st_q.xprev && !st_q.xs[1])
                                    : (st_q.pre == LAST));
    assign dir_up = st_q.ds[1];
endmodule

// File: rtl/urt_core.sv
module urt_core
    import urt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             count_up,
    input  logic             co_mode,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rld,
    output logic             evt_up,
    output logic             evt_dn,
    output logic             tf,
    output logic             xf,
    output logic             co
);
    core_st_t st_d, st_q;
    logic     cnt_wr;
    logic     up_eff;
    logic     wrap_up, wrap_dn;

    always_comb begin
        st_d    = st_q;
        cnt_wr  = wr_en && (wr_addr == A_CNT_LO || wr_addr == A_CNT_HI);
        up_eff  = co_mode || count_up;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;

        // counting step; a counter byte write cancels it
        if (tick && !cnt_wr) begin
            if (up_eff) begin
                if (st_q.cnt == '1) begin
                    st_d.cnt = st_q.rld;
                    wrap_up  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == st_q.rld) begin
                    st_d.cnt = '1;
                    wrap_dn  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end

        // software writes
        if (wr_en) begin
            case (wr_addr)
                A_CNT_LO: st_d.cnt[7:0]       = wr_data;
                A_CNT_HI: st_d.cnt[CNT_W-1:8] = wr_data;
                A_RLD_LO: st_d.rld[7:0]       = wr_data;
                A_RLD_HI: st_d.rld[CNT_W-1:8] = wr_data;
                A_FLAGS: begin
                    st_d.tf = wr_data[0];
                    st_d.xf = wr_data[1];
                end
                default: ;
            endcase
        end

        // hardware flag update wins over the write above
        if ((wrap_up || wrap_dn) && !co_mode) begin
            st_d.tf = 1'b1;
            st_d.xf = ~st_q.xf;
        end

        // square-wave output
        if (!co_mode) begin
            st_d.co = 1'b0;
        end else if (wrap_up) begin
            st_d.co = ~st_q.co;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign rld    = st_q.rld;
    assign tf     = st_q.tf;
    assign xf     = st_q.xf;
    assign co     = st_q.co;
    assign evt_up = wrap_up && !co_mode;
    assign evt_dn = wrap_dn && !co_mode;
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
    import urt_pkg::*;
#(
    parameter int DIV = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ext_sel,
    input  logic       dir_en,
    input  logic       dir_pin,
    input  logic       ext_clk_pin,
    input  logic       clkout_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       tmr_flag,
    output logic       ext_flag,
    output logic       clk_out
);
    logic             tick;
    logic             dir_up;
    logic             co_mode;
    logic             count_up;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] rld_w;
    logic             evt_up, evt_dn;

    assign co_mode  = clkout_en && !ext_sel && run;
    assign count_up = !dir_en || dir_up;

    urt_tick_src #(.DIV(DIV)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ext_sel (ext_sel),
        .dir_pin (dir_pin),
        .ext_pin (ext_clk_pin),
        .tick    (tick),
        .dir_up  (dir_up)
    );

    urt_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count_up (count_up),
        .co_mode  (co_mode),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cnt      (cnt_w),
        .rld      (rld_w),
        .evt_up   (evt_up),
        .evt_dn   (evt_dn),
        .tf       (tmr_flag),
        .xf       (ext_flag),
        .co       (clk_out)
    );
endmodule

// File: rtl/urt_checker.sv
module urt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        co_mode,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [15:0] cnt,
    input logic [15:0] rld,
    input logic        evt_up,
    input logic        evt_dn,
    input logic        tmr_flag,
    input logic        ext_flag,
    input logic        clk_out
);
    logic cnt_wr, flag_wr;
    assign cnt_wr  = wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1);
    assign flag_wr = wr_en && (wr_addr == 3'd4);

    assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dn |=> (cnt == 16'hFFFF));

    assert_up_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_up && !(wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3))) |=> (cnt == $past(rld)));

    assert_flag_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_up || evt_dn) |=> (tmr_flag && (ext_flag != $past(ext_flag))));

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    assert_clk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !co_mode |=> !clk_out);

    assert_no_irq_clkout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (co_mode && !flag_wr) |=> ($stable(tmr_flag) && $stable(ext_flag)));
endmodule

bind updown_reload_timer urt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .co_mode  (co_mode),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt      (cnt_w),
    .rld      (rld_w),
    .evt_up   (evt_up),
    .evt_dn   (evt_dn),
    .tmr_flag (tmr_flag),
    .ext_flag (ext_flag),
    .clk_out  (clk_out)
);

// File: tb/updown_reload_timer_bench.sv
module updown_reload_timer_bench;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, ext_sel = 1'b0, dir_en = 1'b0, dir_pin = 1'b0;
    logic       ext_clk_pin = 1'b1, clkout_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tmr_flag, ext_flag, clk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    updown_reload_timer #(.DIV(DIV)) u_updown_reload_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_sel(ext_sel),
        .dir_en(dir_en), .dir_pin(dir_pin), .ext_clk_pin(ext_clk_pin),
        .clkout_en(clkout_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_flag(tmr_flag), .ext_flag(ext_flag),
        .clk_out(clk_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] r);
        run = 1'b0;
        wr(3'd0, c[7:0]);
        wr(3'd1, c[15:8]);
        wr(3'd2, r[7:0]);
        wr(3'd3, r[15:8]);
        wr(3'd4, 8'h00);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_xf(output int cyc);
        logic s;
        s = ext_flag;
        cyc = 0;
        while (ext_flag == s && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_co(output int cyc);
        logic s;
        s = clk_out;
        cyc = 0;
        while (clk_out == s && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic pulse();
        ext_clk_pin = 1'b0;
        repeat (4) @(negedge clk);
        ext_clk_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    logic [15:0] up_start [3] = '{16'hFFF8, 16'hFFFE, 16'hFFFF};
    logic [15:0] up_rld   [3] = '{16'hFFF0, 16'hFFFA, 16'hFFFF};
    logic [15:0] dn_rld   [4] = '{16'hFFE0, 16'hFFF5, 16'hFFFE, 16'hFFFF};

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 tmr_flag", tmr_flag, 0);
        chk("R1 ext_flag", ext_flag, 0);
        chk("R1 clk_out", clk_out, 0);
        // R1: count 0 and reload 0 -> first down step wraps
        dir_en = 1'b1; dir_pin = 1'b0;
        repeat (3) @(negedge clk);
        run = 1'b1;
        wait_xf(cyc);
        chk("R1 first down wrap cycles", cyc, DIV);
        chk("R1 tmr_flag after wrap", tmr_flag, 1);

        // R4: up-count sweep
        dir_en = 1'b1; dir_pin = 1'b1;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                setup(up_start[i], up_rld[j]);
                run = 1'b1;
                wait_xf(cyc);
                chk("R4 first overflow cycles", cyc, (32'h10000 - up_start[i]) * DIV);
                chk("R5 tmr_flag set", tmr_flag, 1);
                wait_xf(cyc);
                chk("R4 reload period cycles", cyc, (32'h10000 - up_rld[j]) * DIV);
            end
        end

        // R4: dir_en=0 counts up regardless of pin
        dir_en = 1'b0; dir_pin = 1'b0;
        setup(16'hFFFC, 16'hFFF8);
        run = 1'b1;
        wait_xf(cyc);
        chk("R4 dir disabled counts up", cyc, 4 * DIV);

        // R3: down-count sweep
        dir_en = 1'b1; dir_pin = 1'b0;
        for (int j = 0; j < 4; j++) begin
            for (int k = 0; k < 3; k++) begin
                int s;
                s = (k == 0) ? int'(dn_rld[j]) : (k == 1) ? int'(dn_rld[j]) + 3 : 32'hFFFF;
                if (s > 32'hFFFF) s = 32'hFFFF;
                setup(16'(s), dn_rld[j]);
                run = 1'b1;
                wait_xf(cyc);
                chk("R3 first underflow cycles", cyc, (s - int'(dn_rld[j]) + 1) * DIV);
                chk("R5 tmr_flag set on underflow", tmr_flag, 1);
                wait_xf(cyc);
                chk("R3 reload 0xFFFF period", cyc, (32'h10000 - dn_rld[j]) * DIV);
            end
        end

        // R5: flag holds and clears by write
        setup(16'hFFFF, 16'hFFF0);
        dir_pin = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b1;
        wait_xf(cyc);
        run = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 tmr_flag holds", tmr_flag, 1);
        chk("R5 ext_flag holds", ext_flag, 1);
        wr(3'd4, 8'h02);
        chk("R5 tmr_flag cleared by write", tmr_flag, 0);
        chk("R5 ext_flag written", ext_flag, 1);

        // R6: write on the wrap edge loses
        setup(16'hFFFE, 16'hFF00);
        run = 1'b1;
        repeat (2 * DIV - 1) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 tmr_flag wins", tmr_flag, 1);
        chk("R6 ext_flag toggled", ext_flag, 1);

        // R7: counter write on the wrap edge cancels the step
        setup(16'hFFFE, 16'hFF00);
        run = 1'b1;
        repeat (2 * DIV - 1) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hF0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 no wrap on counter write", tmr_flag, 0);
        t = 2 * DIV;
        wait_xf(cyc);
        chk("R7 overflow after override", t + cyc, (2 + 16) * DIV);

        // R2: stopped timer does not count
        setup(16'hFFFF, 16'h0000);
        repeat (40) @(negedge clk);
        chk("R2 stopped no wrap", tmr_flag, 0);

        // R2: external source
        ext_sel = 1'b1; dir_pin = 1'b1;
        setup(16'hFFFD, 16'h1234);
        for (int p = 0; p < 4; p++) pulse();
        chk("R2 ext pulses ignored when stopped", tmr_flag, 0);
        run = 1'b1;
        pulse();
        pulse();
        chk("R2 two ext edges no wrap", tmr_flag, 0);
        pulse();
        chk("R2 third ext edge wraps", tmr_flag, 1);
        run = 1'b0; ext_sel = 1'b0;

        // R8/R9: square-wave mode
        dir_en = 1'b1; dir_pin = 1'b0;
        setup(16'hFFF8, 16'hFFF8);
        clkout_en = 1'b1;
        run = 1'b1;
        wait_co(cyc);
        chk("R8 first half period", cyc, 8 * DIV);
        wait_co(cyc);
        chk("R8 half period", cyc, 8 * DIV);
        wait_co(cyc);
        chk("R8 next half period", cyc, 8 * DIV);
        chk("R9 tmr_flag stays clear", tmr_flag, 0);
        chk("R9 ext_flag unchanged", ext_flag, 0);
        setup(16'hFFF0, 16'hFFF0);
        clkout_en = 1'b1;
        run = 1'b1;
        wait_co(cyc);
        chk("R8 reload FFF0 half period", cyc, 16 * DIV);
        clkout_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 clk_out low outside mode", clk_out, 0);
        run = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule